// File: doc/BRIEF.md
# Single-Cycle Range Renormalization Unit

This unit is the range-update stage of a regular-mode binary arithmetic encoder. It holds the 9-bit coding interval range as internal state. For each bin it takes the bin value, the most-probable-symbol (MPS) value and the least-probable-symbol (LPS) sub-range. It computes the MPS sub-range (current range minus LPS range) and picks one of the two sub-ranges:

- a bin equal to the MPS value keeps the MPS sub-range;
- any other bin takes the LPS sub-range.

The selected sub-range is renormalized in the same cycle. A leading-one detector finds how many left shifts bring its most significant set bit to bit 8. One barrel shift then applies that count, with no iterative loop.

The new range, the shift count and the MPS sub-range are registered and presented one cycle after the input strobe. The low-update stage downstream consumes the shift count and the MPS sub-range.

The caller keeps the LPS range between 6 and half the current range, the bound a regular-mode probability table respects. A new bin may arrive on every cycle.

Top module: `range_renorm`

## Requirements
- R1: While `rst_ni` is low and after its release, `range_o` is 510, `out_valid_o` is 0, `shift_o` is 0 and `rmps_o` is 0 until the first bin is accepted.
- R2: After every accepted bin, `range_o` lies in 256..510, which means bit 8 is set.
- R3: One cycle after an accepted bin, `rmps_o` equals the range before that bin minus `lps_range_i`.
- R4: When `bin_i` equals `mps_i`, the new range is the MPS sub-range shifted left by `shift_o`. In that case `shift_o` is 0 if the sub-range is at least 256, and 1 otherwise.
- R5: When `bin_i` differs from `mps_i`, the new range is `lps_range_i` shifted left by `shift_o`, and `shift_o` is the number of leading zeros of `lps_range_i` viewed as a 9-bit value. It lies in 1..6.
- R6: A cycle with `bin_valid_i` low leaves `range_o` unchanged and drives `out_valid_o` low on the following cycle.
- R7: `out_valid_o` is high exactly in the cycle after `bin_valid_i` was high.
- R8: Bins presented on consecutive cycles are each coded against the range produced by the bin before, with no gap. The result matches a shift-until-at-least-256 loop model for any legal sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bin_valid_i | input | 1 | Strobe: a bin is presented this cycle |
| bin_i | input | 1 | Bin value to encode |
| mps_i | input | 1 | Most probable symbol value of the context |
| lps_range_i | input | 8 | LPS sub-range, 6 up to half the current range |
| out_valid_o | output | 1 | Registered results belong to a bin accepted last cycle |
| range_o | output | 9 | Current (renormalized) interval range |
| shift_o | output | 4 | Number of renormalization shifts for the last bin |
| rmps_o | output | 9 | MPS sub-range of the last bin, before renormalization |

## Verification
The embedded properties check the following on every cycle:

- the normalized range always has its top bit set;
- the MPS sub-range output is the previous range minus the previous LPS input;
- the shift bounds hold on each path (0..1 for MPS, 1..6 for LPS);
- an idle cycle holds the range;
- the valid output tracks the strobe by one cycle.

Only the bench's scenarios show that the exact renormalized value and shift count match a loop-based reference across long back-to-back sequences and at the 128 and 256 boundaries. The same holds for the restoration of the 510 range by a reset in mid-stream.

// File: rtl/range_renorm_pkg.sv
package range_renorm_pkg;

  typedef enum logic {
    PATH_MPS = 1'b0,
    PATH_LPS = 1'b1
  } path_e;

  // Reset range: all ones except LSB
  function automatic int unsigned init_range(int unsigned w);
    return (1 << w) - 2;
  endfunction

endpackage

// File: rtl/range_select.sv
module range_select
  import range_renorm_pkg::*;
#(
  parameter int unsigned RANGE_W = 9,
  localparam int unsigned LPS_W  = RANGE_W - 1
) (
  input  logic [RANGE_W-1:0] range_i,
  input  logic [LPS_W-1:0]   lps_i,
  input  logic               bin_i,
  input  logic               mps_i,
  output logic [RANGE_W-1:0] rmps_o,
  output logic [RANGE_W-1:0] sel_o,
  output path_e              path_o
);

  logic [RANGE_W-1:0] lps_ext;

  assign lps_ext = {1'b0, lps_i};
  assign rmps_o  = range_i - lps_ext;
  assign path_o  = (bin_i == mps_i) ? PATH_MPS : PATH_LPS;
  assign sel_o   = (path_o == PATH_MPS) ? rmps_o : lps_ext;

endmodule

// File: rtl/lead_one_det.sv
module lead_one_det #(
  parameter int unsigned W   = 9,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic [W-1:0]  in_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);

  logic found;

  // Scan from MSB; count of zeros above the first one
  always_comb begin
    cnt_o = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && in_i[i]) begin
        cnt_o = CW'(W - 1 - i);
        found = 1'b1;
      end
    end
  end

  assign zero_o = ~|in_i;

endmodule

// File: rtl/barrel_shl.sv
module barrel_shl #(
  parameter int unsigned W   = 9,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic [W-1:0]  in_i,
  input  logic [CW-1:0] amt_i,
  output logic [W-1:0]  out_o
);

  logic [W-1:0] stg [CW+1];

  assign stg[0] = in_i;

  for (genvar g = 0; g < CW; g++) begin : g_stage
    assign stg[g+1] = amt_i[g] ? (stg[g] << (1 << g)) : stg[g];
  end

  assign out_o = stg[CW];

endmodule

// File: rtl/range_renorm.sv
module range_renorm
  import range_renorm_pkg::*;
#(
  parameter int unsigned RANGE_W  = 9,
  parameter int unsigned LPS_MIN  = 6,
  localparam int unsigned LPS_W   = RANGE_W - 1,
  localparam int unsigned SHIFT_W = $clog2(RANGE_W),
  localparam int unsigned LPS_MAX_SHIFT = RANGE_W - $clog2(LPS_MIN + 1),
  localparam logic [RANGE_W-1:0] RANGE_RST = RANGE_W'(init_range(RANGE_W))
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bin_valid_i,
  input  logic               bin_i,
  input  logic               mps_i,
  input  logic [LPS_W-1:0]   lps_range_i,
  output logic               out_valid_o,
  output logic [RANGE_W-1:0] range_o,
  output logic [SHIFT_W-1:0] shift_o,
  output logic [RANGE_W-1:0] rmps_o
);

  logic [RANGE_W-1:0] range_q;
  logic [RANGE_W-1:0] rmps_d, sel_d, norm_d;
  logic [SHIFT_W-1:0] cnt_d;
  logic               sel_zero;
  path_e              path_d;

  range_select #(.RANGE_W(RANGE_W)) i_select (
    .range_i (range_q),
    .lps_i   (lps_range_i),
    .bin_i   (bin_i),
    .mps_i   (mps_i),
    .rmps_o  (rmps_d),
    .sel_o   (sel_d),
    .path_o  (path_d)
  );

  lead_one_det #(.W(RANGE_W)) i_lod (
    .in_i   (sel_d),
    .cnt_o  (cnt_d),
    .zero_o (sel_zero)
  );

  barrel_shl #(.W(RANGE_W)) i_shl (
    .in_i  (sel_d),
    .amt_i (cnt_d),
    .out_o (norm_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      range_q     <= RANGE_RST;
      shift_o     <= '0;
      rmps_o      <= '0;
      out_valid_o <= 1'b0;
    end else begin
      out_valid_o <= bin_valid_i;
      if (bin_valid_i) begin
        range_q <= norm_d;
        shift_o <= cnt_d;
        rmps_o  <= rmps_d;
      end
    end
  end

  assign range_o = range_q;

  AST_RANGE_NORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    range_o[RANGE_W-1]); // R2

  AST_SEL_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bin_valid_i |-> !sel_zero); // R5

  AST_RMPS_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bin_valid_i |=> rmps_o == $past(range_o) - RANGE_W'($past(lps_range_i))); // R3

  AST_MPS_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bin_valid_i && bin_i == mps_i) |=> shift_o <= SHIFT_W'(1)); // R4

  AST_LPS_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bin_valid_i && bin_i != mps_i) |=>
      (shift_o >= SHIFT_W'(1) && shift_o <= SHIFT_W'(LPS_MAX_SHIFT))); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bin_valid_i |=> $stable(range_o) && !out_valid_o); // R6

  AST_VALID_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bin_valid_i |=> out_valid_o); // R7

endmodule

// File: tb/test_range_renorm.sv
module test_range_renorm;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bin_valid = 1'b0;
  logic       bin = 1'b0;
  logic       mps = 1'b0;
  logic [7:0] lps = 8'd0;
  logic       out_valid;
  logic [8:0] range_v;
  logic [3:0] shift_v;
  logic [8:0] rmps_v;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10ns clk = ~clk;

  range_renorm i_range_renorm (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bin_valid_i (bin_valid),
    .bin_i       (bin),
    .mps_i       (mps),
    .lps_range_i (lps),
    .out_valid_o (out_valid),
    .range_o     (range_v),
    .shift_o     (shift_v),
    .rmps_o      (rmps_v)
  );

  // {bin, mps, lps[8], exp_range[9], exp_shift[4], exp_rmps[9]}
  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'd100, 9'd410, 4'd0, 9'd410},
    {1'b1, 1'b0, 8'd200, 9'd400, 4'd1, 9'd210},
    {1'b1, 1'b1, 8'd150, 9'd500, 4'd1, 9'd250},
    {1'b0, 1'b1, 8'd6,   9'd384, 4'd6, 9'd494},
    {1'b1, 1'b1, 8'd128, 9'd256, 4'd0, 9'd256},
    {1'b0, 1'b1, 8'd128, 9'd256, 4'd1, 9'd128},
    {1'b0, 1'b0, 8'd128, 9'd256, 4'd1, 9'd128},
    {1'b1, 1'b0, 8'd7,   9'd448, 4'd6, 9'd249},
    {1'b0, 1'b1, 8'd31,  9'd496, 4'd4, 9'd417},
    {1'b1, 1'b1, 8'd63,  9'd433, 4'd0, 9'd433}
  };

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(logic b, logic m, logic [7:0] l);
    bin_valid = 1'b1;
    bin = b;
    mps = m;
    lps = l;
  endtask

  // Loop-based reference renormalization
  task automatic ref_step(input int rng, input logic b, input logic m, input int l,
                          output int nrng, output int nsh, output int nrmps);
    int s;
    nrmps = rng - l;
    s = (b == m) ? nrmps : l;
    nsh = 0;
    while (s < 256) begin
      s = s << 1;
      nsh++;
    end
    nrng = s;
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int mrng, nrng, nsh, nrmps;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 range in reset", int'(range_v), 510);
    check("R1 valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 range after reset", int'(range_v), 510);
    check("R1 shift after reset", int'(shift_v), 0);
    check("R1 rmps after reset", int'(rmps_v), 0);
    check("R1 valid after reset", int'(out_valid), 0);

    // Table walk, back-to-back (R8), MPS R4 / LPS R5 / rmps R3 / valid R7
    drive(VEC[0][31], VEC[0][30], VEC[0][29:22]);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check("R7 out_valid", int'(out_valid), 1);
      check(VEC[i][31] == VEC[i][30] ? "R4 range" : "R5 range",
            int'(range_v), int'(VEC[i][21:13]));
      check(VEC[i][31] == VEC[i][30] ? "R4 shift" : "R5 shift",
            int'(shift_v), int'(VEC[i][12:9]));
      check("R3 rmps", int'(rmps_v), int'(VEC[i][8:0]));
      check("R2 range msb", int'(range_v[8]), 1);
      if (i + 1 < NV) drive(VEC[i+1][31], VEC[i+1][30], VEC[i+1][29:22]);
      else bin_valid = 1'b0;
    end

    // R6: idle cycles, inputs changed but not strobed
    bin = 1'b1; mps = 1'b0; lps = 8'd9;
    @(negedge clk);
    check("R6 idle valid", int'(out_valid), 0);
    check("R6 idle range", int'(range_v), 433);
    @(negedge clk);
    check("R6 idle range hold", int'(range_v), 433);

    // R8: long sequence vs loop model
    mrng = 433;
    for (int k = 0; k < 4000; k++) begin
      logic b, m;
      int l, lim;
      b = 1'($urandom);
      m = 1'($urandom);
      lim = mrng >> 1;
      l = 6 + int'($urandom % unsigned'(lim - 5));
      if (k % 97 == 0) l = 6;
      if (k % 89 == 0) l = lim;
      drive(b, m, 8'(l));
      ref_step(mrng, b, m, l, nrng, nsh, nrmps);
      @(negedge clk);
      check("R8 range", int'(range_v), nrng);
      check("R8 shift", int'(shift_v), nsh);
      check("R3 rmps seq", int'(rmps_v), nrmps);
      mrng = nrng;
      if (k % 50 == 49) begin
        bin_valid = 1'b0;
        @(negedge clk);
        check("R6 gap range", int'(range_v), mrng);
        check("R7 gap valid", int'(out_valid), 0);
      end
    end
    bin_valid = 1'b0;

    // R1: reset in mid-stream restores 510
    @(negedge clk);
    rst_n = 1'b0;
    #3ns;
    check("R1 async reset range", int'(range_v), 510);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset valid", int'(out_valid), 0);
    drive(1'b0, 1'b0, 8'd255);
    @(negedge clk);
    check("R4 after reset range", int'(range_v), 255 * 2);
    check("R4 after reset shift", int'(shift_v), 1);
    bin_valid = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule